// File: doc/BRIEF.md
# Comma-Aligning Deserializer with Dual Byte Clocks

This block is the receive-side frame demultiplexer of a 10-bit serial link that carries 8B/10B symbols. It runs on a bit-rate clock and takes one serial bit per cycle. The bit comes from one of two line inputs, or from the local transmit serializer when loopback is on. It samples that bit and shifts it into a 10-bit window. On every word boundary it presents the window as a parallel word.

The block watches the window for the 7-bit comma sequence at every bit position. When byte synchronisation is enabled and a comma completes a window that is off the current boundary, the block drops the partial word and starts a new boundary at the comma. It emits the comma word at once. A flag marks each output word that starts with a comma. Two complementary byte clocks toggle with every new word, so successive words land on the rising edges of the two clocks in turn. With synchronisation disabled, the boundary stays on its fixed 10-cycle cadence and alignment is left to external logic.

Top module: `comma_deser`

## Requirements
- R1: While rst_ni is low and until the first word is emitted, word_o is 0, comma_o is 0, rbc0_o is 0 and rbc1_o is 1.
- R2: Serial bits arrive least significant first. The first received bit of a word is placed in word_o[0] and the tenth in word_o[9]. A bit presented before clock edge n is sampled at edge n. If it is the last bit of a word, the word appears at edge n+1. The first word after reset is made of bits 1 to 10 and appears at edge 11.
- R3: With sync_en_i high, a comma that completes a full 10-bit window at a new offset makes that window the next output word at the edge after its tenth bit. The partial word in progress is discarded and following words are counted from there. Both comma polarities are recognised: received order 0011111 (word_o[6:0] = 7'b1111100) and received order 1100000 (word_o[6:0] = 7'b0000011).
- R4: comma_o changes only together with a new word. It is 1 exactly when that word's bits [6:0] hold one of the two comma patterns.
- R5: With sync_en_i low, words are emitted every 10 bit cycles from reset regardless of commas.
- R6: rbc1_o is always the complement of rbc0_o. Both toggle exactly when a new word is emitted, and word_o changes only then. Words 1, 3, 5 and so on after reset arrive with a rising rbc0_o, and words 2, 4, 6 and so on arrive with a rising rbc1_o.
- R7: With loop_en_i low, line_sel_i = 0 feeds line_a_i to the receiver and line_sel_i = 1 feeds line_b_i.
- R8: With loop_en_i high, tx_loop_i feeds the receiver whatever line_sel_i is.
- R9: The gap between two successive words never exceeds one word time plus one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_a_i | input | 1 | Serial line input A |
| line_b_i | input | 1 | Serial line input B |
| line_sel_i | input | 1 | Line select: 0 = A, 1 = B |
| loop_en_i | input | 1 | Use the transmit serial stream instead of a line |
| tx_loop_i | input | 1 | Transmit serializer output bit |
| sync_en_i | input | 1 | Enable comma realignment |
| word_o | output | 10 | Parallel word, first received bit in bit 0 |
| comma_o | output | 1 | Current word carries an aligned comma |
| rbc0_o | output | 1 | Byte clock 0, rises on odd words |
| rbc1_o | output | 1 | Byte clock 1, complement of byte clock 0 |

## Verification
A bit presented before edge n is sampled at edge n and shifted at edge n+1. The word that ends with that bit therefore appears at edge n+1. A realigned comma word also appears one edge after its tenth bit, not at the old boundary. The bench counts edges from reset release. A monitor logs every byte-clock toggle at the falling edge, with the edge number, word and flag at that moment. Each scenario compares the logged edge numbers against the bit positions it drove, so both early and late words are caught.

// File: rtl/comma_deser_pkg.sv
package comma_deser_pkg;
  localparam int WORD_W  = 10;
  localparam int COMMA_W = 7;
  // Comma with first-received bit at index 0: received order 0,0,1,1,1,1,1
  localparam logic [COMMA_W-1:0] COMMA_POS = 7'b1111100;
endpackage

// File: rtl/rx_src_sel.sv
module rx_src_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_a_i,
  input  logic line_b_i,
  input  logic line_sel_i,
  input  logic loop_en_i,
  input  logic tx_loop_i,
  output logic bit_o,
  output logic vld_o
);
  logic src;

  always_comb begin
    if (loop_en_i)       src = tx_loop_i;
    else if (line_sel_i) src = line_b_i;
    else                 src = line_a_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      bit_o <= src;
      vld_o <= 1'b1;
    end
  end
endmodule

// File: rtl/comma_match.sv
module comma_match
  import comma_deser_pkg::*;
#(
  parameter int                 PAT_W = COMMA_W,
  parameter logic [PAT_W-1:0]   PAT   = COMMA_POS
) (
  input  logic [PAT_W-1:0] win_i,
  output logic             hit_o
);
  logic [1:0] pol_hit;

  for (genvar p = 0; p < 2; p++) begin : g_pol
    localparam logic [PAT_W-1:0] REF = (p == 0) ? PAT : ~PAT;
    assign pol_hit[p] = (win_i == REF);
  end

  assign hit_o = |pol_hit;
endmodule

// File: rtl/word_framer.sv
module word_framer
  import comma_deser_pkg::*;
#(
  parameter int W   = WORD_W,
  parameter int CW  = COMMA_W,
  localparam int CNT_W = $clog2(W)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         bit_i,
  input  logic         vld_i,
  input  logic         sync_en_i,
  output logic [W-1:0] word_o,
  output logic         comma_o,
  output logic         emit_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     sr_q, win;
  logic [CNT_W-1:0] cnt_q;
  logic             full_q, hit, last, realign;

  assign win = {bit_i, sr_q[W-1:1]};

  comma_match #(.PAT_W(CW), .PAT(COMMA_POS)) u_match (
    .win_i (win[CW-1:0]),
    .hit_o (hit)
  );

  assign last    = vld_i && (cnt_q == LAST);
  // realign only on a window filled with received bits
  assign realign = vld_i && sync_en_i && hit && (full_q || last);
  assign emit_o  = last || realign;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q    <= '0;
      cnt_q   <= '0;
      full_q  <= 1'b0;
      word_o  <= '0;
      comma_o <= 1'b0;
    end else if (vld_i) begin
      sr_q <= win;
      if (last) full_q <= 1'b1;
      if (emit_o) begin
        cnt_q   <= '0;
        word_o  <= win;
        comma_o <= hit;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/byte_clk_gen.sv
module byte_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic emit_i,
  output logic rbc0_o,
  output logic rbc1_o
);
  logic phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= 1'b0;
    else if (emit_i) phase_q <= ~phase_q;
  end

  assign rbc0_o = phase_q;
  assign rbc1_o = ~phase_q;
endmodule

// File: rtl/comma_deser.sv
module comma_deser
  import comma_deser_pkg::*;
#(
  parameter int WORD_W_P  = WORD_W,
  parameter int COMMA_W_P = COMMA_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                line_a_i,
  input  logic                line_b_i,
  input  logic                line_sel_i,
  input  logic                loop_en_i,
  input  logic                tx_loop_i,
  input  logic                sync_en_i,
  output logic [WORD_W_P-1:0] word_o,
  output logic                comma_o,
  output logic                rbc0_o,
  output logic                rbc1_o
);
  logic samp_bit, samp_vld, emit;

  rx_src_sel u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_a_i   (line_a_i),
    .line_b_i   (line_b_i),
    .line_sel_i (line_sel_i),
    .loop_en_i  (loop_en_i),
    .tx_loop_i  (tx_loop_i),
    .bit_o      (samp_bit),
    .vld_o      (samp_vld)
  );

  word_framer #(.W(WORD_W_P), .CW(COMMA_W_P)) u_framer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (samp_bit),
    .vld_i     (samp_vld),
    .sync_en_i (sync_en_i),
    .word_o    (word_o),
    .comma_o   (comma_o),
    .emit_o    (emit)
  );

  byte_clk_gen u_bclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .emit_i (emit),
    .rbc0_o (rbc0_o),
    .rbc1_o (rbc1_o)
  );
endmodule

// File: rtl/comma_deser_chk.sv
module comma_deser_chk
  import comma_deser_pkg::*;
#(
  parameter int W = WORD_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] word_o,
  input logic         comma_o,
  input logic         rbc0_o,
  input logic         rbc1_o
);
  localparam int GAP_W = $clog2(W + 3);
  logic             prev_q;
  logic [GAP_W-1:0] gap_q;
  logic             ev;

  assign ev = (rbc0_o != prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      gap_q  <= '0;
    end else begin
      prev_q <= rbc0_o;
      if (ev) gap_q <= '0;
      else if (gap_q != '1) gap_q <= gap_q + 1'b1;
    end
  end

  AST_CLK_COMPL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rbc1_o == ~rbc0_o); // R6

  AST_WORD_ON_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_o != $past(word_o)) |-> (rbc0_o != $past(rbc0_o))); // R6

  AST_FLAG_ON_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comma_o != $past(comma_o)) |-> (rbc0_o != $past(rbc0_o))); // R4

  AST_FLAG_PATTERN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comma_o |-> (word_o[COMMA_W-1:0] == COMMA_POS ||
                 word_o[COMMA_W-1:0] == ~COMMA_POS)); // R4

  AST_WORD_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gap_q <= GAP_W'(W + 1)); // R9
endmodule

bind comma_deser comma_deser_chk #(.W(WORD_W_P)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .word_o  (word_o),
  .comma_o (comma_o),
  .rbc0_o  (rbc0_o),
  .rbc1_o  (rbc1_o)
);

// File: tb/comma_deser_bench.sv
module comma_deser_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_a = 1'b0, line_b = 1'b0, line_sel = 1'b0;
  logic       loop_en = 1'b0, tx_loop = 1'b0, sync_en = 1'b1;
  logic [9:0] word;
  logic       comma, rbc0, rbc1;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  int route = 0;  // 0 = line A, 1 = line B, 2 = loopback

  int         ev_n = 0;
  int         ev_cyc  [64];
  logic [9:0] ev_word [64];
  logic       ev_flag [64];
  logic       ev_rbc0 [64];
  logic       prev_rbc0 = 1'b0;

  always #2.5 clk = ~clk;

  comma_deser u_comma_deser (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .line_a_i   (line_a),
    .line_b_i   (line_b),
    .line_sel_i (line_sel),
    .loop_en_i  (loop_en),
    .tx_loop_i  (tx_loop),
    .sync_en_i  (sync_en),
    .word_o     (word),
    .comma_o    (comma),
    .rbc0_o     (rbc0),
    .rbc1_o     (rbc1)
  );

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;
  end

  // word event monitor
  always @(negedge clk) begin
    if (!rst_ni) begin
      ev_n = 0;
      prev_rbc0 = 1'b0;
    end else if (rbc0 != prev_rbc0) begin
      if (ev_n < 64) begin
        ev_cyc[ev_n]  = cyc;
        ev_word[ev_n] = word;
        ev_flag[ev_n] = comma;
        ev_rbc0[ev_n] = rbc0;
        ev_n = ev_n + 1;
      end
      prev_rbc0 = rbc0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic drive_bit(input logic b);
    line_a  = (route == 0) ? b : ~b;
    line_b  = (route == 1) ? b : ~b;
    tx_loop = (route == 2) ? b : ~b;
    @(negedge clk);
  endtask

  task automatic send(input logic [9:0] v, input int n);
    for (int i = 0; i < n; i++) drive_bit(v[i]);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic expect_ev(input int k, input int w, input bit f, input int c);
    chk(ev_n > k, "R2 word count", ev_n, k + 1);
    if (ev_n > k) begin
      chk(ev_word[k] == 10'(w), "R2/R3 word value", int'(ev_word[k]), w);
      chk(ev_flag[k] == f, "R4 comma flag", int'(ev_flag[k]), int'(f));
      chk(ev_cyc[k] == c, "R2 word edge", ev_cyc[k], c);
      chk(ev_rbc0[k] == ((k % 2) == 0), "R6 byte clock phase", int'(ev_rbc0[k]),
          int'((k % 2) == 0));
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(word == 10'd0, "R1 word", int'(word), 0);
    chk(comma == 1'b0, "R1 flag", int'(comma), 0);
    chk(rbc0 == 1'b0, "R1 rbc0", int'(rbc0), 0);
    chk(rbc1 == 1'b1, "R1 rbc1", int'(rbc1), 1);
  endtask

  // R3: comma at offset 3 realigns; partial word dropped
  task automatic t_aligned();
    route = 0; line_sel = 1'b0; loop_en = 1'b0; sync_en = 1'b1;
    do_reset();
    send(10'h000, 13);
    send(10'h17C, 10);
    send(10'h155, 10);
    send(10'h2AA, 10);
    repeat (3) @(negedge clk);
    expect_ev(0, 10'h000, 1'b0, 11);
    expect_ev(1, 10'h3E0, 1'b0, 21);
    expect_ev(2, 10'h17C, 1'b1, 24);  // R3 realigned comma word
    expect_ev(3, 10'h155, 1'b0, 34);
    expect_ev(4, 10'h2AA, 1'b0, 44);
  endtask

  // R5: same stream, sync off, fixed cadence
  task automatic t_nosync();
    route = 0; line_sel = 1'b0; loop_en = 1'b0; sync_en = 1'b0;
    do_reset();
    send(10'h000, 13);
    send(10'h17C, 10);
    send(10'h155, 10);
    send(10'h2AA, 10);
    repeat (3) @(negedge clk);
    expect_ev(0, 10'h000, 1'b0, 11);
    expect_ev(1, 10'h3E0, 1'b0, 21);
    expect_ev(2, 10'h2AA, 1'b0, 31);  // R5 boundary unchanged
    expect_ev(3, 10'h152, 1'b0, 41);
    sync_en = 1'b1;
  endtask

  // R3: complement comma at offset 5
  task automatic t_complement();
    route = 0; line_sel = 1'b0; loop_en = 1'b0; sync_en = 1'b1;
    do_reset();
    send(10'h3FF, 5);
    send(10'h283, 10);
    send(10'h2AA, 10);
    repeat (3) @(negedge clk);
    expect_ev(0, 10'h07F, 1'b0, 11);
    expect_ev(1, 10'h283, 1'b1, 16);
    expect_ev(2, 10'h2AA, 1'b0, 26);
  endtask

  // R7/R8: source selection; other inputs carry the complement stream
  task automatic t_source(input int r, input logic sel, input logic lp);
    route = r; line_sel = sel; loop_en = lp; sync_en = 1'b1;
    do_reset();
    send(10'h17C, 10);
    send(10'h155, 10);
    repeat (3) @(negedge clk);
    if (lp) begin
      chk(ev_n > 1 && ev_word[0] == 10'h17C && ev_word[1] == 10'h155,
          "R8 loopback source", int'(ev_word[0]), 'h17C);
    end else begin
      chk(ev_n > 1 && ev_word[0] == 10'h17C && ev_word[1] == 10'h155,
          "R7 line source", int'(ev_word[0]), 'h17C);
    end
    expect_ev(0, 10'h17C, 1'b1, 11);
    expect_ev(1, 10'h155, 1'b0, 21);
    loop_en = 1'b0;
  endtask

  initial begin
    #200000;
    n_fail++;
    n_chk++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_aligned();
    t_nosync();
    t_complement();
    t_source(0, 1'b0, 1'b0);
    t_source(1, 1'b1, 1'b0);
    t_source(2, 1'b1, 1'b1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule